// File: doc/BRIEF.md
# Modem line event mask and wake controller

This block sits beside a UART's modem status logic. It watches the four modem control inputs (clear-to-send, data-set-ready, ring indicator and carrier detect) and the serial receive line. Each of these inputs passes through a synchroniser before an edge detector looks at it. Every detected modem event sets a sticky change flag. That flag can then reach three separate destinations: the modem-status interrupt, the power-management event output used in the low-power D2 state, and the wake-up request for the auto-sleep controller.

A mask register is cleared at reset, so by default every event reaches all three destinations. Each modem line has one mask bit, and that bit blocks all three destinations at once. The change flag itself is still recorded. A separate mask bit decides whether a start bit on the serial input, seen while in D2, may raise the power-management event. The bus decoder writes the mask. Reading the modem status register clears the flags. The power state and the interrupt enable arrive as plain inputs.

Top module: `mdw_top`

## Requirements
- R1: After reset, mask_rdata is 0x00, delta_flags is 0 and modem_irq, pm_event and wake_req are all low.
- R2: A write with mask_we stores bits 0 to 3 and bit 5 of mask_wdata one clock later. Bits 4, 6 and 7 always read back as zero. Writing 0xFF therefore reads back 0x2F.
- R3: delta_flags bit 0 (CTS), bit 1 (DSR) and bit 3 (DCD) set when their line changes level in either direction. The flag shows on the third rising edge after the new level is first sampled, and not on the second.
- R4: delta_flags bit 2 (RI) sets only on a high-to-low transition of line_ri. A rising edge leaves it clear.
- R5: A set change flag stays set until status_rd is high at a clock edge, which clears all flags. An event that arrives at that same edge is kept.
- R6: modem_irq is high exactly when msint_en is high and some change flag is set whose mask bit (bits 0 to 3, in the order CTS, DSR, RI, DCD) is clear.
- R7: wake_req is high whenever some unmasked change flag is set, whatever the values of msint_en and in_d2.
- R8: While in_d2 is high, an unmasked change flag drives pm_event high. While in_d2 is low, pm_event stays low.
- R9: A start bit (a high-to-low edge on line_sin) seen while in_d2 is high sets a pending wake. It raises pm_event unless mask bit 5 is set. It does not affect wake_req. The pending wake is cleared one clock after in_d2 goes low.
- R10: When a modem line's mask bit is set, its events still set the change flag, but they raise none of modem_irq, pm_event or wake_req.
- R11: Edges on the synchronised inputs are ignored until SYNC_STAGES+1 clocks after reset. A line that is held high through reset sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_cts | input | 1 | Clear-to-send line level (asynchronous) |
| line_dsr | input | 1 | Data-set-ready line level (asynchronous) |
| line_ri | input | 1 | Ring indicator line level (asynchronous) |
| line_dcd | input | 1 | Carrier detect line level (asynchronous) |
| line_sin | input | 1 | Serial receive line level (asynchronous, idles high) |
| mask_we | input | 1 | Write strobe for the mask register |
| mask_wdata | input | 8 | Mask write data |
| mask_rdata | output | 8 | Current mask register contents |
| status_rd | input | 1 | Modem status read, clears change flags |
| msint_en | input | 1 | Modem-status interrupt enable |
| in_d2 | input | 1 | Device is in low-power state D2 |
| delta_flags | output | 4 | Sticky change flags: bit0 CTS, bit1 DSR, bit2 RI, bit3 DCD |
| modem_irq | output | 1 | Modem-status interrupt request |
| pm_event | output | 1 | Power-management event level |
| wake_req | output | 1 | Wake-up request for auto-sleep |

## Verification
A flag captured in the wrong slot shows up on delta_flags three clocks after the line edge. The same fault shows on the same clock in modem_irq, wake_req or pm_event, because all three are formed combinationally from the flags and the mask. A mask bit stored in the wrong place appears on mask_rdata one clock after the write. It also shows when the next event for that line fails to be suppressed. A pending start-bit wake that does not clear shows the first time D2 is entered again with no new start bit: pm_event is high when it should be low.

// File: rtl/mdw_pkg.sv
package mdw_pkg;

    localparam int MASK_W    = 8;
    localparam int NUM_MODEM = 4;

    // Mask bit positions; the per-line order matches the change-flag order.
    localparam int MB_CTS = 0;
    localparam int MB_DSR = 1;
    localparam int MB_RI  = 2;
    localparam int MB_DCD = 3;
    localparam int MB_SIN = 5;

    // Bits that hold state; bit 4 is forced to zero, bits 7:6 are reserved.
    localparam logic [MASK_W-1:0] MASK_KEEP = 8'b0010_1111;

    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } modem_t;

    typedef struct packed {
        modem_t modem;
        logic   sin;
    } line_t;

    // Any change on CTS/DSR/DCD, falling edge only on RI.
    function automatic modem_t modem_events(modem_t prev, modem_t cur);
        modem_t ev;
        ev.cts = prev.cts ^ cur.cts;
        ev.dsr = prev.dsr ^ cur.dsr;
        ev.dcd = prev.dcd ^ cur.dcd;
        ev.ri  = prev.ri & ~cur.ri;
        return ev;
    endfunction

endpackage

// File: rtl/mdw_sync.sv
module mdw_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] stg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_q <= '0;
        end else begin
            stg_q[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg_q[i] <= stg_q[i-1];
            end
        end
    end

    assign q = stg_q[STAGES-1];

endmodule

// File: rtl/mdw_mask_reg.sv
module mdw_mask_reg
    import mdw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [MASK_W-1:0] wdata,
    output logic [MASK_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (we) begin
            q <= wdata & MASK_KEEP;
        end
    end

    a_r2_write_takes: assert property (@(posedge clk) disable iff (rst)
        we |=> (q[3:0] == $past(wdata[3:0]) && q[MB_SIN] == $past(wdata[MB_SIN])));

endmodule

// File: rtl/mdw_delta.sv
module mdw_delta
    import mdw_pkg::*;
#(
    parameter int ARM_LEN = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  modem_t               cur,
    input  logic                 sin_cur,
    input  logic                 clr,
    input  logic                 in_d2,
    output logic [NUM_MODEM-1:0] delta,
    output logic                 sin_pend
);

    logic [ARM_LEN-1:0] arm_q;
    logic               armed;
    modem_t             prev_q;
    logic               prev_sin_q;
    modem_t             evt;
    logic               sin_fall;

    assign armed    = arm_q[ARM_LEN-1];
    assign evt      = armed ? modem_events(prev_q, cur) : '0;
    assign sin_fall = armed & prev_sin_q & ~sin_cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_q      <= '0;
            prev_q     <= '0;
            prev_sin_q <= 1'b0;
            delta      <= '0;
            sin_pend   <= 1'b0;
        end else begin
            arm_q      <= {arm_q[ARM_LEN-2:0], 1'b1};
            prev_q     <= cur;
            prev_sin_q <= sin_cur;
            delta      <= (clr ? '0 : delta) | evt;
            if (!in_d2) begin
                sin_pend <= 1'b0;
            end else if (sin_fall) begin
                sin_pend <= 1'b1;
            end
        end
    end

    a_r5_flags_sticky: assert property (@(posedge clk) disable iff (rst)
        (delta != '0 && !clr) |=> ((delta & $past(delta)) == $past(delta)));

    a_r5_read_clears: assert property (@(posedge clk) disable iff (rst)
        (clr && evt == '0) |=> (delta == '0));

    a_r11_quiet_unarmed: assert property (@(posedge clk) disable iff (rst)
        !armed |=> (delta == '0 && !sin_pend));

    a_r9_d2_exit_clears: assert property (@(posedge clk) disable iff (rst)
        !in_d2 |=> !sin_pend);

endmodule

// File: rtl/mdw_top.sv
module mdw_top
    import mdw_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 line_cts,
    input  logic                 line_dsr,
    input  logic                 line_ri,
    input  logic                 line_dcd,
    input  logic                 line_sin,
    input  logic                 mask_we,
    input  logic [MASK_W-1:0]    mask_wdata,
    output logic [MASK_W-1:0]    mask_rdata,
    input  logic                 status_rd,
    input  logic                 msint_en,
    input  logic                 in_d2,
    output logic [NUM_MODEM-1:0] delta_flags,
    output logic                 modem_irq,
    output logic                 pm_event,
    output logic                 wake_req
);

    localparam int LINE_W  = $bits(line_t);
    localparam int ARM_LEN = SYNC_STAGES + 1;

    line_t               raw;
    line_t               synced;
    logic [NUM_MODEM-1:0] flags;
    logic [NUM_MODEM-1:0] live;
    logic                 sin_pend;
    logic                 any_live;

    assign raw.modem.cts = line_cts;
    assign raw.modem.dsr = line_dsr;
    assign raw.modem.ri  = line_ri;
    assign raw.modem.dcd = line_dcd;
    assign raw.sin       = line_sin;

    mdw_sync #(
        .WIDTH  (LINE_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (synced)
    );

    mdw_mask_reg u_mask (
        .clk   (clk),
        .rst   (rst),
        .we    (mask_we),
        .wdata (mask_wdata),
        .q     (mask_rdata)
    );

    mdw_delta #(
        .ARM_LEN (ARM_LEN)
    ) u_delta (
        .clk      (clk),
        .rst      (rst),
        .cur      (synced.modem),
        .sin_cur  (synced.sin),
        .clr      (status_rd),
        .in_d2    (in_d2),
        .delta    (flags),
        .sin_pend (sin_pend)
    );

    // One mask bit per line gates that line for every destination.
    for (genvar g = 0; g < NUM_MODEM; g++) begin : g_gate
        assign live[g] = flags[g] & ~mask_rdata[g];
    end

    assign any_live    = |live;
    assign delta_flags = flags;
    assign wake_req    = any_live;
    assign modem_irq   = any_live & msint_en;
    assign pm_event    = in_d2 & (any_live | (sin_pend & ~mask_rdata[MB_SIN]));

endmodule

// File: tb/mdw_top_bench.sv
`timescale 1ns/1ps
module mdw_top_bench;

    localparam int F_MASK  = 0;
    localparam int F_DELTA = 1;
    localparam int F_IRQ   = 2;
    localparam int F_PME   = 3;
    localparam int F_WAKE  = 4;

    typedef struct {
        string      req;
        int         field;
        logic [7:0] exp;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line_cts = 1'b1, line_dsr = 1'b0, line_ri = 1'b0, line_dcd = 1'b0, line_sin = 1'b1;
    logic       mask_we = 1'b0;
    logic [7:0] mask_wdata = '0;
    logic [7:0] mask_rdata;
    logic       status_rd = 1'b0, msint_en = 1'b0, in_d2 = 1'b0;
    logic [3:0] delta_flags;
    logic       modem_irq, pm_event, wake_req;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    finished = 1'b0;
    item_t sb_q[$];

    always #2.5 clk = ~clk;

    mdw_top u_mdw_top (
        .clk (clk), .rst (rst),
        .line_cts (line_cts), .line_dsr (line_dsr), .line_ri (line_ri),
        .line_dcd (line_dcd), .line_sin (line_sin),
        .mask_we (mask_we), .mask_wdata (mask_wdata), .mask_rdata (mask_rdata),
        .status_rd (status_rd), .msint_en (msint_en), .in_d2 (in_d2),
        .delta_flags (delta_flags), .modem_irq (modem_irq),
        .pm_event (pm_event), .wake_req (wake_req)
    );

    function automatic logic [7:0] observe(int field);
        case (field)
            F_MASK:  return mask_rdata;
            F_DELTA: return {4'b0, delta_flags};
            F_IRQ:   return {7'b0, modem_irq};
            F_PME:   return {7'b0, pm_event};
            default: return {7'b0, wake_req};
        endcase
    endfunction

    // Monitor: compare queued expectations away from the rising edge.
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it  = sb_q.pop_front();
            act = observe(it.field);
            n_tests++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s field %0d: actual 0x%0h expected 0x%0h", it.req, it.field, act, it.exp);
            end
        end
    end

    task automatic expect_item(string req, int field, logic [7:0] exp);
        item_t it;
        it.req = req; it.field = field; it.exp = exp;
        sb_q.push_back(it);
    endtask

    task automatic expect_outs(string req, logic [3:0] d, logic irq, logic pme, logic wk);
        expect_item(req, F_DELTA, {4'b0, d});
        expect_item(req, F_IRQ,   {7'b0, irq});
        expect_item(req, F_PME,   {7'b0, pme});
        expect_item(req, F_WAKE,  {7'b0, wk});
    endtask

    // Advance n rising edges; inputs change 1 ns after each edge.
    task automatic cyc(int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic write_mask(logic [7:0] v);
        mask_we = 1'b1; mask_wdata = v;
        cyc(1);
        mask_we = 1'b0;
    endtask

    task automatic read_status();
        status_rd = 1'b1;
        cyc(1);
        status_rd = 1'b0;
    endtask

    initial begin
        cyc(3);
        rst = 1'b0;
        expect_item("R1", F_MASK, 8'h00);
        expect_outs("R1", 4'b0000, 1'b0, 1'b0, 1'b0);
        cyc(6);
        // CTS held high through reset must not register
        expect_outs("R11", 4'b0000, 1'b0, 1'b0, 1'b0);
        cyc(1);

        write_mask(8'hFF);
        expect_item("R2", F_MASK, 8'h2F);
        cyc(1);
        write_mask(8'h00);
        expect_item("R2", F_MASK, 8'h00);
        cyc(1);

        // CTS change, interrupt enabled, not in D2
        msint_en = 1'b1;
        line_cts = 1'b0;
        cyc(2);
        expect_item("R3", F_DELTA, 8'h00);
        cyc(1);
        expect_outs("R3", 4'b0001, 1'b1, 1'b0, 1'b1);
        cyc(2);
        read_status();
        expect_outs("R5", 4'b0000, 1'b0, 1'b0, 1'b0);
        cyc(1);

        // RI rising ignored, falling counted
        line_ri = 1'b1;
        cyc(5);
        expect_item("R4", F_DELTA, 8'h00);
        cyc(1);
        line_ri = 1'b0;
        cyc(3);
        expect_item("R4", F_DELTA, 8'h04);
        cyc(1);

        // interrupt enable gates only the interrupt
        msint_en = 1'b0;
        cyc(1);
        expect_item("R6", F_IRQ, 8'h00);
        expect_item("R7", F_WAKE, 8'h01);
        cyc(1);
        read_status();
        msint_en = 1'b1;
        cyc(1);

        // masked CTS: flag recorded, no destination, even in D2
        write_mask(8'h01);
        in_d2 = 1'b1;
        line_cts = 1'b1;
        cyc(3);
        expect_outs("R10", 4'b0001, 1'b0, 1'b0, 1'b0);
        cyc(1);
        read_status();
        write_mask(8'h00);
        cyc(1);

        // DSR change in D2 raises the power event
        line_dsr = 1'b1;
        cyc(3);
        expect_outs("R8", 4'b0010, 1'b1, 1'b1, 1'b1);
        cyc(1);
        in_d2 = 1'b0;
        cyc(1);
        expect_item("R8", F_PME, 8'h00);
        expect_item("R7", F_WAKE, 8'h01);
        cyc(1);
        read_status();
        in_d2 = 1'b1;
        cyc(1);
        expect_item("R8", F_PME, 8'h00);
        cyc(1);

        // start bit in D2
        line_sin = 1'b0;
        cyc(3);
        expect_outs("R9", 4'b0000, 1'b0, 1'b1, 1'b0);
        cyc(1);
        line_sin = 1'b1;
        in_d2 = 1'b0;
        cyc(1);
        in_d2 = 1'b1;
        cyc(1);
        expect_item("R9", F_PME, 8'h00);
        cyc(3);
        write_mask(8'h20);
        line_sin = 1'b0;
        cyc(4);
        expect_item("R9", F_PME, 8'h00);
        cyc(1);
        line_sin = 1'b1;
        in_d2 = 1'b0;
        write_mask(8'h00);
        cyc(4);

        // read and new event on the same edge: old flag cleared, new kept
        line_cts = 1'b0;
        cyc(3);
        expect_item("R5", F_DELTA, 8'h01);
        cyc(1);
        line_dcd = 1'b1;
        cyc(2);
        status_rd = 1'b1;
        cyc(1);
        status_rd = 1'b0;
        expect_item("R5", F_DELTA, 8'h08);
        expect_item("R6", F_IRQ, 8'h01);
        cyc(3);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule